// File: doc/BRIEF.md
# Control Transfer Protocol Guard

This block follows the host's progress through one control transfer on a device's default endpoint and decides, for every transaction, whether the device answers with ACK or STALL. Transactions reach it already decoded. The block receives a one-cycle event carrying the token kind, the toggle of the data packet, the packet length and the configured maximum packet size. For a SETUP it also receives the direction and the zero-length indication of the request, which are parsed elsewhere. It also samples the firmware's level flag that marks the last data packet as handled.

The block moves between idle, data and status stages. It checks each event against the stage it is in. It returns its verdict one clock after the event, and it raises a status flag whenever it finds a protocol violation. Every STALL covers one transaction and drops the transfer back to idle, so the next packet begins a new transfer. A SETUP received with the wrong toggle is still acknowledged, and the STALL is applied to the transaction that follows it.

Top module: `ctl_xfer_guard`

## Requirements
- R1: When `rst` or `bus_reset` is high, the block clears `hs_valid` and `force_stall`, returns to idle and drops any deferred stall.
- R2: `tok_kind` uses the codes 0 = SETUP, 1 = OUT and 2 = IN. An event with one of these codes produces `hs_valid` high for exactly one cycle, one clock after `tok_valid`, with `hs_stall` high for STALL and low for ACK. Code 3 produces no handshake and leaves the stage unchanged.
- R3: A SETUP with `data_pid1` low is answered with ACK and starts a transfer. The block enters the data stage, with the data direction taken from `setup_dir_in`. If `setup_len_zero` is high, it goes directly to the status stage, which then expects IN.
- R4: An IN received while idle is answered with STALL.
- R5: A SETUP with `data_pid1` high is answered with ACK and raises `force_stall`. The next IN or OUT is then answered with STALL. A later SETUP replaces the deferred stall.
- R6: An OUT status packet with `data_pid1` low is answered with STALL. With `data_pid1` high it is answered with ACK, and the transfer ends in idle.
- R7: In the data stage with `data_end` high, a token in the data direction is answered with STALL. In the status stage, a token in the data direction (OUT, for a zero-length request) is also answered with STALL.
- R8: An OUT whose `pkt_len` is greater than `max_pkt` is answered with STALL in any stage. A length equal to `max_pkt` is accepted.
- R9: In the data stage, data-direction tokens are answered with ACK while `data_end` is low. A token in the opposite direction is taken as the status transaction, whatever the state of `data_end`.
- R10: Every STALL arrives with `force_stall` high in the same cycle and returns the block to idle. An OUT received while idle and within size is answered with ACK.
- R11: `force_stall` stays high until a SETUP with `data_pid1` low is accepted or R1 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset seen on the link, synchronous, clears the transfer |
| tok_valid | input | 1 | One-cycle event: a transaction was received |
| tok_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN, 3 ignored |
| data_pid1 | input | 1 | Toggle of the data packet was DATA1 |
| pkt_len | input | LEN_W | Received data packet length in bytes |
| max_pkt | input | LEN_W | Configured maximum packet size |
| setup_dir_in | input | 1 | Request direction is device-to-host (SETUP only) |
| setup_len_zero | input | 1 | Request has no data stage (SETUP only) |
| data_end | input | 1 | Firmware marks the last data packet as handled |
| hs_valid | output | 1 | Handshake decision valid |
| hs_stall | output | 1 | 1 = STALL, 0 = ACK |
| force_stall | output | 1 | A protocol violation was detected |

## Verification
The bench runs transfers in both directions and zero-length transfers. It then presses on the places where stage tracking usually breaks. These are the STALL deferred by a bad SETUP toggle, which a design applying it at once would show as a stalled SETUP, and the overrun after `data_end`, which a design that ignores the flag would keep acknowledging. It also covers the boundary where `pkt_len` equals `max_pkt`, where an off-by-one comparator stalls a legal packet. The bench confirms that a completed or stalled transfer really returns to idle, because a following IN must be stalled. It also checks that the ignored token code and a mid-transfer bus reset leave no deferred stall or stale stage behind.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

    localparam logic [1:0] TK_SETUP = 2'd0;
    localparam logic [1:0] TK_OUT   = 2'd1;
    localparam logic [1:0] TK_IN    = 2'd2;
    localparam logic [1:0] TK_NONE  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_STATUS = 2'd2
    } stage_e;

    typedef enum logic [2:0] {
        CS_NONE,
        CS_NO_SETUP,
        CS_STATUS_TOGGLE,
        CS_SETUP_TOGGLE,
        CS_OVERRUN,
        CS_OVERSIZE,
        CS_DEFERRED
    } cause_e;

    // Transfer context held between transactions
    typedef struct packed {
        stage_e stage;
        logic   dir_in;   // data stage direction; status runs the other way
        logic   defer;    // stall owed to the next IN/OUT
    } ctx_t;

    typedef struct packed {
        logic stall;
        logic flag_set;
        logic flag_clr;
        ctx_t nxt;
    } verdict_t;

    localparam ctx_t CTX_IDLE = '{stage: ST_IDLE, dir_in: 1'b0, defer: 1'b0};

    function automatic logic is_known_token(input logic [1:0] kind);
        return kind != TK_NONE;
    endfunction

endpackage

// File: rtl/ctl_verdict.sv
module ctl_verdict
    import ctl_xfer_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  ctx_t             ctx,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             data_pid1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             setup_dir_in,
    input  logic             setup_len_zero,
    input  logic             data_end,
    output logic             tok_ok,
    output verdict_t         v
);

    logic   is_setup, is_out, is_in, same_dir, status_bad, oversize;
    cause_e cause;

    assign tok_ok     = tok_valid && is_known_token(tok_kind);
    assign is_setup   = tok_ok && (tok_kind == TK_SETUP);
    assign is_out     = tok_ok && (tok_kind == TK_OUT);
    assign is_in      = tok_ok && (tok_kind == TK_IN);
    assign same_dir   = (is_in == ctx.dir_in);
    assign status_bad = is_out && !data_pid1;
    assign oversize   = is_out && (pkt_len > max_pkt);

    always_comb begin
        cause      = CS_NONE;
        v.stall    = 1'b0;
        v.flag_set = 1'b0;
        v.flag_clr = 1'b0;
        v.nxt      = ctx;
        if (is_setup) begin
            if (data_pid1) begin
                // acknowledged now, stall owed to the following transaction
                cause        = CS_SETUP_TOGGLE;
                v.flag_set   = 1'b1;
                v.nxt        = CTX_IDLE;
                v.nxt.defer  = 1'b1;
            end else begin
                v.flag_clr   = 1'b1;
                v.nxt.defer  = 1'b0;
                v.nxt.dir_in = setup_dir_in & ~setup_len_zero;
                v.nxt.stage  = setup_len_zero ? ST_STATUS : ST_DATA;
            end
        end else if (is_out || is_in) begin
            if (ctx.defer) begin
                cause = CS_DEFERRED;
            end else if (oversize) begin
                cause = CS_OVERSIZE;
            end else begin
                case (ctx.stage)
                    ST_IDLE: begin
                        if (is_in) cause = CS_NO_SETUP;
                    end
                    ST_DATA: begin
                        if (same_dir) begin
                            if (data_end) cause = CS_OVERRUN;
                        end else if (status_bad) begin
                            cause = CS_STATUS_TOGGLE;
                        end else begin
                            v.nxt.stage = ST_IDLE;
                        end
                    end
                    default: begin
                        if (same_dir)        cause = CS_OVERRUN;
                        else if (status_bad) cause = CS_STATUS_TOGGLE;
                        else                 v.nxt.stage = ST_IDLE;
                    end
                endcase
            end
            if (cause != CS_NONE) begin
                v.stall    = 1'b1;
                v.flag_set = 1'b1;
                v.nxt      = CTX_IDLE;
            end
        end
    end

endmodule

// File: rtl/ctl_ctx_reg.sv
module ctl_ctx_reg
    import ctl_xfer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_reset,
    input  logic     tok_ok,
    input  verdict_t v,
    output ctx_t     ctx,
    output logic     force_stall
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            ctx         <= CTX_IDLE;
            force_stall <= 1'b0;
        end else if (tok_ok) begin
            ctx <= v.nxt;
            if (v.flag_set)      force_stall <= 1'b1;
            else if (v.flag_clr) force_stall <= 1'b0;
        end
    end

    // R5: a deferred stall only exists outside any transfer
    a_r5_defer_idle: assert property (@(posedge clk) disable iff (rst)
        ctx.defer |-> (ctx.stage == ST_IDLE));

    // R11: the flag falls only on a clean SETUP or a bus reset
    a_r11_flag_release: assert property (@(posedge clk) disable iff (rst)
        $fell(force_stall) |-> ($past(bus_reset) || $past(tok_ok && v.flag_clr)));

endmodule

// File: rtl/ctl_hs_reg.sv
module ctl_hs_reg (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic tok_ok,
    input  logic stall,
    output logic hs_valid,
    output logic hs_stall
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            hs_valid <= 1'b0;
            hs_stall <= 1'b0;
        end else begin
            hs_valid <= tok_ok;
            hs_stall <= tok_ok && stall;
        end
    end

    // R2: a decision is issued only for an accepted event one cycle earlier
    a_r2_hs_follows_tok: assert property (@(posedge clk) disable iff (rst || bus_reset)
        hs_valid |-> $past(tok_ok));

endmodule

// File: rtl/ctl_xfer_guard.sv
module ctl_xfer_guard
    import ctl_xfer_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             data_pid1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             setup_dir_in,
    input  logic             setup_len_zero,
    input  logic             data_end,
    output logic             hs_valid,
    output logic             hs_stall,
    output logic             force_stall
);

    ctx_t     ctx;
    verdict_t v;
    logic     tok_ok;

    ctl_verdict #(.LEN_W(LEN_W)) u_verdict (
        .ctx            (ctx),
        .tok_valid      (tok_valid),
        .tok_kind       (tok_kind),
        .data_pid1      (data_pid1),
        .pkt_len        (pkt_len),
        .max_pkt        (max_pkt),
        .setup_dir_in   (setup_dir_in),
        .setup_len_zero (setup_len_zero),
        .data_end       (data_end),
        .tok_ok         (tok_ok),
        .v              (v)
    );

    ctl_ctx_reg u_ctx (
        .clk         (clk),
        .rst         (rst),
        .bus_reset   (bus_reset),
        .tok_ok      (tok_ok),
        .v           (v),
        .ctx         (ctx),
        .force_stall (force_stall)
    );

    ctl_hs_reg u_hs (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .tok_ok    (tok_ok),
        .stall     (v.stall),
        .hs_valid  (hs_valid),
        .hs_stall  (hs_stall)
    );

    // R5: a SETUP is never refused, even with a bad toggle
    a_r5_setup_acked: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (hs_valid && $past(tok_valid && tok_kind == TK_SETUP)) |-> !hs_stall);

    // R10: a stall always comes with the flag and an aborted transfer
    a_r10_stall_flags: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (hs_valid && hs_stall) |-> (force_stall && ctx.stage == ST_IDLE && !ctx.defer));

    // R2: the unused token code gets no handshake
    a_r2_none_silent: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (tok_valid && tok_kind == TK_NONE) |=> !hs_valid);

    // R1: bus reset leaves nothing pending
    a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (!hs_valid && !force_stall && ctx == CTX_IDLE));

endmodule

// File: tb/sim_ctl_xfer_guard.sv
`timescale 1ns/1ps
module sim_ctl_xfer_guard;

    localparam int LEN_W = 11;
    localparam int NV    = 29;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_reset = 1'b0;
    logic             tok_valid = 1'b0;
    logic [1:0]       tok_kind = 2'd0;
    logic             data_pid1 = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [LEN_W-1:0] max_pkt = 11'd64;
    logic             setup_dir_in = 1'b0;
    logic             setup_len_zero = 1'b0;
    logic             data_end = 1'b0;
    logic             hs_valid, hs_stall, force_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ctl_xfer_guard #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .data_pid1(data_pid1), .pkt_len(pkt_len),
        .max_pkt(max_pkt), .setup_dir_in(setup_dir_in),
        .setup_len_zero(setup_len_zero), .data_end(data_end),
        .hs_valid(hs_valid), .hs_stall(hs_stall), .force_stall(force_stall)
    );

    // vector: req[22:19] kind[18:17] pid1[16] dir_in[15] len_zero[14]
    //         data_end[13] len[12:2] exp_stall[1] exp_flag[0]
    function automatic logic [22:0] mk(input int req, input int kind, input bit p,
                                       input bit d, input bit z, input bit e,
                                       input int len, input bit es, input bit ef);
        return {req[3:0], kind[1:0], p, d, z, e, len[10:0], es, ef};
    endfunction

    localparam logic [22:0] TBL [NV] = '{
        mk(4, 2, 0,0,0,0,  0, 1,1),  // R4 IN while idle
        mk(3, 0, 0,1,0,0,  8, 0,0),  // R3 SETUP, IN data
        mk(9, 2, 0,0,0,0,  0, 0,0),  // R9 data IN before data_end
        mk(7, 2, 0,0,0,1,  0, 1,1),  // R7 IN after data_end
        mk(10,2, 0,0,0,0,  0, 1,1),  // R10 transfer aborted, IN idle
        mk(3, 0, 0,1,0,0,  8, 0,0),  // R3 new SETUP clears flag
        mk(9, 2, 0,0,0,0,  0, 0,0),  // R9
        mk(6, 1, 1,0,0,0,  0, 0,0),  // R6 status OUT DATA1 ack
        mk(6, 2, 0,0,0,0,  0, 1,1),  // R6 transfer ended: IN idle stalls
        mk(3, 0, 0,0,0,0,  8, 0,0),  // R3 SETUP, OUT data
        mk(8, 1, 0,0,0,0, 64, 0,0),  // R8 length equal to max
        mk(8, 1, 0,0,0,0, 65, 1,1),  // R8 length above max
        mk(3, 0, 0,0,0,0,  8, 0,0),  // R3
        mk(7, 1, 0,0,0,1, 10, 1,1),  // R7 OUT after data_end
        mk(3, 0, 0,0,0,0,  8, 0,0),  // R3
        mk(9, 2, 0,0,0,0,  0, 0,0),  // R9 status IN of write
        mk(10,1, 0,0,0,0,  8, 0,0),  // R10 OUT idle ack
        mk(3, 0, 0,1,1,0,  8, 0,0),  // R3 zero-length request
        mk(7, 1, 1,0,0,0,  0, 1,1),  // R7 OUT in zero-length status
        mk(3, 0, 0,0,1,0,  8, 0,0),  // R3
        mk(3, 2, 0,0,0,0,  0, 0,0),  // R3 status IN ack
        mk(3, 0, 0,1,0,0,  8, 0,0),  // R3
        mk(6, 1, 0,0,0,0,  0, 1,1),  // R6 status OUT DATA0
        mk(5, 0, 1,1,0,0,  8, 0,1),  // R5 SETUP DATA1 acked, flag up
        mk(5, 1, 1,0,0,0,  4, 1,1),  // R5 deferred stall
        mk(11,1, 1,0,0,0,  4, 0,1),  // R11 flag held, OUT idle ack
        mk(5, 0, 1,1,0,0,  8, 0,1),  // R5
        mk(11,0, 0,1,0,0,  8, 0,0),  // R11 clean SETUP replaces defer
        mk(5, 2, 0,0,0,0,  0, 0,0)   // R5 no stall left pending
    };

    task automatic send(input logic [1:0] k, input logic p, input logic d,
                        input logic z, input logic e, input logic [LEN_W-1:0] l);
        @(negedge clk);
        tok_kind = k; data_pid1 = p; setup_dir_in = d; setup_len_zero = z;
        data_end = e; pkt_len = l; tok_valid = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic chk(input int req, input logic ev, input logic es, input logic ef);
        logic [2:0] got, exp;
        got = {hs_valid, hs_stall, force_stall};
        exp = {ev, es, ef};
        if (!ev) begin
            got[1] = 1'b0;
            exp[1] = 1'b0;
        end
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: valid/stall/flag got %b expected %b", req, got, exp);
        end
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(1, 1'b0, 1'b0, 1'b0);                         // R1 reset state

        for (int i = 0; i < NV; i++) begin
            send(TBL[i][18:17], TBL[i][16], TBL[i][15], TBL[i][14], TBL[i][13], TBL[i][12:2]);
            chk(int'(TBL[i][22:19]), 1'b1, TBL[i][1], TBL[i][0]);
        end

        // R2: one-cycle decision, then silence
        send(2'd0, 0, 1, 0, 0, 11'd8);
        chk(2, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk(2, 1'b0, 1'b0, 1'b0);
        // R2: code 3 ignored, stage kept (data IN still acked)
        send(2'd3, 0, 0, 0, 1, 11'd0);
        chk(2, 1'b0, 1'b0, 1'b0);
        send(2'd2, 0, 0, 0, 0, 11'd0);
        chk(2, 1'b1, 1'b0, 1'b0);

        // R1: bus reset drops the flag and the transfer
        send(2'd1, 1, 0, 0, 0, 11'd200);                 // oversize in data IN stage
        chk(8, 1'b1, 1'b1, 1'b1);
        pulse_bus_reset();
        chk(1, 1'b0, 1'b0, 1'b0);
        send(2'd0, 0, 1, 0, 0, 11'd8);
        chk(3, 1'b1, 1'b0, 1'b0);
        pulse_bus_reset();
        send(2'd2, 0, 0, 0, 0, 11'd0);
        chk(1, 1'b1, 1'b1, 1'b1);                         // back in idle
        // R1: deferred stall dropped by bus reset
        send(2'd0, 1, 1, 0, 0, 11'd8);
        chk(5, 1'b1, 1'b0, 1'b1);
        pulse_bus_reset();
        send(2'd1, 1, 0, 0, 0, 11'd4);
        chk(1, 1'b1, 1'b0, 1'b0);

        // R8: a smaller max applies in idle too
        max_pkt = 11'd8;
        send(2'd1, 1, 0, 0, 0, 11'd9);
        chk(8, 1'b1, 1'b1, 1'b1);
        send(2'd1, 1, 0, 0, 0, 11'd8);
        chk(10, 1'b1, 1'b0, 1'b1);                        // R10 idle OUT ok, R11 flag held

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R2: watchdog expired, got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule